// File: doc/BRIEF.md
# Status Register Immediate Write Unit

This unit watches a stream of 32-bit instruction words and acts on one form only: the move of an immediate value into a program status register. It holds two 32-bit status registers. One is the current status register, which carries the condition flags, the endianness bit, the interrupt masks and the mode field. The other is the saved status register. Both are visible on read ports.

When a recognised word arrives, the unit builds a 32-bit write value by rotating an 8-bit constant. It checks the word's condition code against the current flags. It then updates the byte lanes that a 4-bit mask selects, in whichever register bit 22 picks. The processor mode controls which lanes may change. A saved-register write from User or System mode is dropped and flagged as unpredictable. A privileged write that would put an illegal code into the mode field leaves the mode untouched and raises an illegal-state flag.

Top module: `psr_imm_writer`

## Requirements
- R1: A word takes effect only when `instrValid` is high, bits [27:23] are 00110, bits [21:20] are 10 and bits [15:12] are 1111. Any other word, or a low `instrValid`, leaves both registers unchanged and both flags low.
- R2: The write value is bits [7:0] of the word rotated right by 2 × bits [11:8] within 32 bits.
- R3: Mask bit i (word bit 16+i) enables byte lane i (bits 8i+7..8i) of the target register. Unselected lanes keep their value.
- R4: Condition code bits [31:28] are tested against N, Z, C and V, which are current register bits 31, 30, 29 and 28. Codes 0000..1101 are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT and LE in that order. Code 1110 always passes. Code 1111 never passes. A failed condition changes nothing.
- R5: With bit 22 set in User mode (10000) or System mode (11111), the saved register is unchanged and `unpredFlag` is high for exactly one cycle.
- R6: A privileged write to the current register whose new mode field (bits [4:0]) is not one of 10000, 10001, 10010, 10011, 10111, 11011 or 11111 keeps the old mode. It still writes bits [7:5] and the other selected lanes, and raises `illegalFlag` for one cycle. A write with a legal code switches the mode.
- R7: In User mode a current-register write changes only lane 3 (when mask bit 3 is set) and bit 9 (when mask bit 1 is set). Every other requested bit is ignored, and the mode stays User.
- R8: In a privileged mode other than System, bit 22 set writes the selected lanes of the saved register and leaves the current register unchanged.
- R9: Synchronous reset sets the current register to 0x000000D3 (Supervisor mode with both interrupt masks set), clears the saved register, and clears both flags.
- R10: Register updates and flags appear at the clock edge that samples the word. Each flag lasts one cycle and never rises together with the other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word |
| curPsr | output | 32 | Current status register |
| savedPsr | output | 32 | Saved status register |
| unpredFlag | output | 1 | One-cycle pulse: saved write refused in User/System |
| illegalFlag | output | 1 | One-cycle pulse: illegal mode change suppressed |

## Verification
Every result of this block arrives one edge after its word is sampled: the register contents, the unpredictable pulse and the illegal-state pulse. The driver presents each word on a falling edge and queues the expected state of both registers and both flags. The monitor pops that entry a quarter period after the next rising edge, so every comparison falls in the single cycle where that word's effect is visible. Idle cycles are queued after each flagged case, which confirms that the pulses drop after one cycle.

// File: rtl/psrw_pkg.sv
package psrw_pkg;
  localparam int XLEN   = 32;
  localparam int LANES  = XLEN / 8;
  localparam int MODE_W = 5;
  localparam int EBIT   = 9;
  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef struct packed {
    logic [LANES-1:0] laneWe;
    logic             eBitWe;
    logic             keepMode;
    logic             toSaved;
    logic             unpred;
    logic             illegal;
  } psrStrobe_t;

  function automatic logic modeLegal(input logic [MODE_W-1:0] m);
    case (m)
      5'b10000, 5'b10001, 5'b10010, 5'b10011,
      5'b10111, 5'b11011, 5'b11111: modeLegal = 1'b1;
      default:                      modeLegal = 1'b0;
    endcase
  endfunction

  // nzcv: bit3=N bit2=Z bit1=C bit0=V
  function automatic logic condPass(input logic [3:0] cc, input logic [3:0] nzcv);
    logic n, z, c, v;
    n = nzcv[3]; z = nzcv[2]; c = nzcv[1]; v = nzcv[0];
    case (cc)
      4'd0:    condPass = z;
      4'd1:    condPass = !z;
      4'd2:    condPass = c;
      4'd3:    condPass = !c;
      4'd4:    condPass = n;
      4'd5:    condPass = !n;
      4'd6:    condPass = v;
      4'd7:    condPass = !v;
      4'd8:    condPass = c && !z;
      4'd9:    condPass = !c || z;
      4'd10:   condPass = (n == v);
      4'd11:   condPass = (n != v);
      4'd12:   condPass = !z && (n == v);
      4'd13:   condPass = z || (n != v);
      4'd14:   condPass = 1'b1;
      default: condPass = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/psrw_ctrl.sv
module psrw_ctrl
  import psrw_pkg::*;
(
  input  logic              instrValid,
  input  logic [19:0]       instrHi,     // instruction bits [31:12]
  input  logic [3:0]        curFlags,
  input  logic [MODE_W-1:0] curMode,
  input  logic [MODE_W-1:0] newMode,
  output psrStrobe_t        strobe
);
  logic [3:0]       condCode;
  logic [4:0]       opField;
  logic             selSaved;
  logic [1:0]       fixedBits;
  logic [LANES-1:0] laneMask;
  logic [3:0]       onesField;
  logic             isMatch;
  logic             isPriv;
  logic             isUserOrSys;

  assign condCode  = instrHi[19:16];
  assign opField   = instrHi[15:11];
  assign selSaved  = instrHi[10];
  assign fixedBits = instrHi[9:8];
  assign laneMask  = instrHi[7:4];
  assign onesField = instrHi[3:0];

  assign isMatch = instrValid && (opField == 5'b00110) &&
                   (fixedBits == 2'b10) && (onesField == 4'b1111);
  assign isPriv      = (curMode != MODE_USR);
  assign isUserOrSys = (curMode == MODE_USR) || (curMode == MODE_SYS);

  always_comb begin
    strobe = '0;
    if (isMatch && condPass(condCode, curFlags)) begin
      if (selSaved) begin
        if (isUserOrSys) begin
          strobe.unpred = 1'b1;
        end else begin
          strobe.toSaved = 1'b1;
          strobe.laneWe  = laneMask;
        end
      end else if (!isPriv) begin
        strobe.laneWe[LANES-1] = laneMask[LANES-1];
        strobe.eBitWe          = laneMask[EBIT/8];
      end else begin
        strobe.laneWe = laneMask;
        if (laneMask[0] && !modeLegal(newMode)) begin
          strobe.keepMode = 1'b1;
          strobe.illegal  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psrw_datapath.sv
module psrw_datapath
  import psrw_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_CUR = 32'h0000_00D3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [11:0]     immField,
  input  psrStrobe_t      strobe,
  output logic [XLEN-1:0] immVal,
  output logic [XLEN-1:0] curPsr,
  output logic [XLEN-1:0] savedPsr,
  output logic            unpredFlag,
  output logic            illegalFlag
);
  localparam int ROT_W = $clog2(XLEN);

  logic [2*XLEN-1:0] immDouble;
  logic [2*XLEN-1:0] immShifted;
  logic [ROT_W-1:0]  rotAmt;
  logic [XLEN-1:0]   curNext;
  logic [XLEN-1:0]   savedNext;

  assign rotAmt     = ROT_W'({immField[11:8], 1'b0});
  assign immDouble  = {2{{(XLEN-8){1'b0}}, immField[7:0]}};
  assign immShifted = immDouble >> rotAmt;
  assign immVal     = immShifted[XLEN-1:0];

  always_comb begin
    curNext   = curPsr;
    savedNext = savedPsr;
    for (int i = 0; i < LANES; i++) begin
      if (strobe.laneWe[i]) begin
        if (strobe.toSaved) savedNext[i*8 +: 8] = immVal[i*8 +: 8];
        else                curNext[i*8 +: 8]   = immVal[i*8 +: 8];
      end
    end
    if (strobe.eBitWe)   curNext[EBIT] = immVal[EBIT];
    if (strobe.keepMode) curNext[MODE_W-1:0] = curPsr[MODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curPsr      <= RESET_CUR;
      savedPsr    <= '0;
      unpredFlag  <= 1'b0;
      illegalFlag <= 1'b0;
    end else begin
      curPsr      <= curNext;
      savedPsr    <= savedNext;
      unpredFlag  <= strobe.unpred;
      illegalFlag <= strobe.illegal;
    end
  end
endmodule

// File: rtl/psr_imm_writer.sv
module psr_imm_writer
  import psrw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  output logic [31:0] curPsr,
  output logic [31:0] savedPsr,
  output logic        unpredFlag,
  output logic        illegalFlag
);
  psrStrobe_t      strobe;
  logic [XLEN-1:0] immVal;

  psrw_ctrl u_ctrl (
    .instrValid (instrValid),
    .instrHi    (instrWord[31:12]),
    .curFlags   (curPsr[31:28]),
    .curMode    (curPsr[MODE_W-1:0]),
    .newMode    (immVal[MODE_W-1:0]),
    .strobe     (strobe)
  );

  psrw_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .immField    (instrWord[11:0]),
    .strobe      (strobe),
    .immVal      (immVal),
    .curPsr      (curPsr),
    .savedPsr    (savedPsr),
    .unpredFlag  (unpredFlag),
    .illegalFlag (illegalFlag)
  );
endmodule

// File: rtl/psrw_checker.sv
module psrw_checker
  import psrw_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        instrValid,
  input logic [31:0] curPsr,
  input logic [31:0] savedPsr,
  input logic        unpredFlag,
  input logic        illegalFlag
);
  p_idle_no_change_r1: assert property (@(posedge clk) disable iff (rst)
    !instrValid |=> ($stable(curPsr) && $stable(savedPsr) && !unpredFlag && !illegalFlag));

  p_saved_kept_r5: assert property (@(posedge clk) disable iff (rst)
    unpredFlag |-> $stable(savedPsr));

  p_mode_kept_r6: assert property (@(posedge clk) disable iff (rst)
    illegalFlag |-> $stable(curPsr[MODE_W-1:0]));

  p_mode_legal_r6: assert property (@(posedge clk) disable iff (rst)
    modeLegal(curPsr[MODE_W-1:0]));

  p_user_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (curPsr[MODE_W-1:0] == MODE_USR) |=>
      (curPsr[MODE_W-1:0] == MODE_USR) && $stable(curPsr[23:10]) && $stable(curPsr[8:0]));

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(unpredFlag && illegalFlag));
endmodule

bind psr_imm_writer psrw_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .instrValid  (instrValid),
  .curPsr      (curPsr),
  .savedPsr    (savedPsr),
  .unpredFlag  (unpredFlag),
  .illegalFlag (illegalFlag)
);

// File: tb/psr_imm_writer_bench.sv
module psr_imm_writer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] curPsr, savedPsr;
  logic        unpredFlag, illegalFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] cur;
    logic [31:0] saved;
    logic        unp;
    logic        ill;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [31:0] mCur, mSaved;

  always #10 clk = ~clk;  // 50 MHz

  psr_imm_writer u_psr_imm_writer (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .curPsr(curPsr), .savedPsr(savedPsr),
    .unpredFlag(unpredFlag), .illegalFlag(illegalFlag)
  );

  function automatic bit ccOk(input logic [3:0] cc, input logic [31:0] p);
    bit n, z, c, v;
    n = p[31]; z = p[30]; c = p[29]; v = p[28];
    case (cc)
      0: return z;        1: return !z;
      2: return c;        3: return !c;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return c & !z;   9: return !c | z;
      10: return n == v;  11: return n != v;
      12: return !z & (n == v);
      13: return z | (n != v);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit okMode(input logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
  endfunction

  function automatic logic [31:0] mkWord(input logic [3:0] cc, input bit toSaved,
      input logic [3:0] mask, input logic [3:0] rot, input logic [7:0] imm8);
    return {cc, 5'b00110, toSaved, 2'b10, mask, 4'b1111, rot, imm8};
  endfunction

  task automatic drive(input logic [31:0] w, input bit v, input string tag);
    expItem_t e;
    logic [31:0] val;
    logic [4:0]  mode;
    bit user, sys;
    @(negedge clk);
    instrWord  = w;
    instrValid = v;
    e.unp = 0; e.ill = 0;
    val  = ({24'd0, w[7:0]} >> (2 * w[11:8])) | ({24'd0, w[7:0]} << (32 - 2 * w[11:8]));
    mode = mCur[4:0];
    user = (mode == 5'h10); sys = (mode == 5'h1F);
    if (v && w[27:23] == 5'b00110 && w[21:20] == 2'b10 && w[15:12] == 4'hF
        && ccOk(w[31:28], mCur)) begin
      if (w[22]) begin
        if (user || sys) e.unp = 1;
        else for (int i = 0; i < 4; i++) if (w[16+i]) mSaved[i*8 +: 8] = val[i*8 +: 8];
      end else if (user) begin
        if (w[19]) mCur[31:24] = val[31:24];
        if (w[17]) mCur[9] = val[9];
      end else begin
        for (int i = 0; i < 4; i++) if (w[16+i]) mCur[i*8 +: 8] = val[i*8 +: 8];
        if (w[16] && !okMode(val[4:0])) begin
          mCur[4:0] = mode;
          e.ill = 1;
        end
      end
    end
    e.cur = mCur; e.saved = mSaved; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: one quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (curPsr !== e.cur || savedPsr !== e.saved ||
          unpredFlag !== e.unp || illegalFlag !== e.ill) begin
        errors++;
        $display("FAIL %s actual cur=%h saved=%h unp=%b ill=%b expected cur=%h saved=%h unp=%b ill=%b",
                 e.tag, curPsr, savedPsr, unpredFlag, illegalFlag,
                 e.cur, e.saved, e.unp, e.ill);
      end
    end
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9 reset state
    checks++;
    if (curPsr !== 32'h0000_00D3 || savedPsr !== 32'h0 || unpredFlag !== 0 || illegalFlag !== 0) begin
      errors++;
      $display("FAIL R9 actual cur=%h saved=%h expected cur=000000d3 saved=00000000", curPsr, savedPsr);
    end
    mCur = 32'h0000_00D3; mSaved = 0;

    drive(mkWord(4'hE, 0, 4'b1000, 4'd4, 8'hF0), 1, "R2 rotate by 8 into flags");
    drive(mkWord(4'h0, 0, 4'b1000, 4'd1, 8'h01), 1, "R4 EQ pass");
    drive(mkWord(4'h1, 0, 4'b1000, 4'd0, 8'h00), 1, "R4 NE fail");
    drive(mkWord(4'hF, 0, 4'b1000, 4'd0, 8'h00), 1, "R4 code 1111 fails");
    drive(mkWord(4'hE, 1, 4'b0101, 4'd8, 8'hAB), 1, "R8 R3 saved lanes 0,2");
    drive(mkWord(4'hE, 1, 4'b0011, 4'd0, 8'h12), 1, "R3 saved lanes 0,1");
    drive(mkWord(4'hE, 0, 4'b0001, 4'd0, 8'h15), 1, "R6 illegal mode kept");
    drive(32'h0, 0, "R10 illegal flag drops");
    drive(mkWord(4'hE, 0, 4'b0001, 4'd0, 8'hD2), 1, "R6 legal switch to 10010");
    drive(mkWord(4'hE, 0, 4'b1111, 4'd0, 8'hD2) | 32'h0030_0000, 1, "R1 non-matching word");
    drive(mkWord(4'hE, 0, 4'b1000, 4'd0, 8'h00), 0, "R1 valid low");
    drive(mkWord(4'hE, 0, 4'b0001, 4'd0, 8'hDF), 1, "R6 switch to System");
    drive(mkWord(4'hE, 1, 4'b1111, 4'd0, 8'h55), 1, "R5 saved write in System");
    drive(32'h0, 0, "R10 unpred flag drops");
    drive(mkWord(4'hE, 0, 4'b0001, 4'd0, 8'hD0), 1, "R6 switch to User");
    drive(mkWord(4'hE, 0, 4'b1111, 4'd4, 8'hFF), 1, "R7 user full mask");
    drive(mkWord(4'hE, 0, 4'b0011, 4'd12, 8'h02), 1, "R7 user endian bit");
    drive(mkWord(4'hE, 1, 4'b1111, 4'd0, 8'h77), 1, "R5 saved write in User");
    drive(mkWord(4'hA, 0, 4'b1000, 4'd2, 8'h03), 1, "R4 GE pass");
    drive(mkWord(4'h8, 0, 4'b1000, 4'd1, 8'h02), 1, "R4 HI pass");
    drive(mkWord(4'h6, 0, 4'b1000, 4'd0, 8'h00), 1, "R4 VS fail");
    drive(mkWord(4'hB, 0, 4'b1000, 4'd0, 8'h10), 1, "R4 LT pass");
    drive(mkWord(4'hD, 0, 4'b1000, 4'd0, 8'h00), 1, "R4 LE fail");
    drive(32'h0, 0, "R10 idle");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule